// File: doc/BRIEF.md
# Nibble I/O Bus Slave with Switched Auxiliary Registers

This block is a slave on a 4-bit I/O bus. The bus has a 4-bit port address, a 4-bit data bus, and separate read (IN) and write (OUT) strobes. The block holds two example peripheral modules and one switch module.

Each peripheral module has a primary register and an auxiliary register, but it occupies only one port address. A plain access to that address reaches the primary register. To reach the auxiliary register, software first writes the module's address into the switch module, which has a port address of its own. The switch then redirects the next access to that module, and only to that module, into its auxiliary register. After that the switch disarms itself.

One module has a nibble-wide auxiliary register, which takes one access. The other has a byte-wide auxiliary register, which takes two accesses, low nibble first and then high nibble. The switch disarms only after the second of the two. This scheme lets the auxiliary register be reached without spending a second port address on it.

Top module: `auxsw_nibble_bus`

## Requirements
- R1: After reset the switch is disarmed and every register is zero. An IN from address 3, 5 or 15 then returns 0000.
- R2: While the switch is not armed for a module, an OUT to that module's address (3 or 5) writes its primary register. An IN from that address returns the primary register on `rdata` in the same cycle as the `in_stb` pulse.
- R3: An OUT to the switch address 15 arms the switch, with the data nibble as the target address. An IN from address 15 returns the target while the switch is armed and 0000 while it is disarmed.
- R4: When the switch is armed with target 3, the next access (IN or OUT) to address 3 reaches the nibble auxiliary register. The switch then disarms, so later accesses to address 3 reach the primary register again.
- R5: When the switch is armed with target 5, the next two accesses to address 5 reach the byte auxiliary register. The first access carries bits 3:0 and the second carries bits 7:4. The switch disarms after the second. Each new arming restarts at the low nibble.
- R6: While the switch is armed, accesses to any address other than its target and 15 go to primary registers. Such accesses leave the switch armed with the same target.
- R7: An IN from an address with no module behind it (any address other than 3, 5 and 15) returns 0000. An OUT to such an address changes no register.
- R8: `rdata` is 0000 whenever `in_stb` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Port address of the current access |
| wdata | input | 4 | Write data for OUT |
| out_stb | input | 1 | OUT (write) strobe, one cycle per access |
| in_stb | input | 1 | IN (read) strobe, one cycle per access |
| rdata | output | 4 | Read data, valid while in_stb is high |

## Verification
The assertions check four things on every cycle:
- `rdata` is idle when no read is in progress, and reads from empty addresses return zero.
- A switch write arms the switch with its data as the target.
- A nibble auxiliary access disarms the switch.
- Accesses to unrelated modules leave the armed state untouched.

Only the bench scenarios can show the data paths end to end. These include the low-then-high order of the byte auxiliary register across two accesses, the return to primary access after disarming, and the agreement of read-back values with earlier writes over long random mixes of accesses.

// File: rtl/auxsw_nibble_bus.sv
module auxsw_nibble_bus #(
  parameter int W = 4,
  parameter logic [W-1:0] SW_ADDR   = 4'hF,
  parameter logic [W-1:0] NIB_ADDR  = 4'h3,
  parameter logic [W-1:0] BYTE_ADDR = 4'h5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] wdata,
  input  logic         out_stb,
  input  logic         in_stb,
  output logic [W-1:0] rdata
);
  localparam int BW = 2 * W;

  logic          armed;
  logic [W-1:0]  target;
  logic          hi_phase;
  logic [W-1:0]  pri_a, aux_a, pri_b;
  logic [BW-1:0] aux_b;

  wire acc       = in_stb | out_stb;
  wire sw_wr     = out_stb && (addr == SW_ADDR);
  wire hit_a     = (addr == NIB_ADDR);
  wire hit_b     = (addr == BYTE_ADDR);
  wire aux_a_sel = armed && (target == NIB_ADDR) && hit_a;
  wire aux_b_sel = armed && (target == BYTE_ADDR) && hit_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      target   <= '0;
      hi_phase <= 1'b0;
    end else if (sw_wr) begin
      armed    <= 1'b1;
      target   <= wdata;
      hi_phase <= 1'b0;
    end else if (acc && aux_a_sel) begin
      armed <= 1'b0;
    end else if (acc && aux_b_sel) begin
      if (hi_phase) begin
        armed    <= 1'b0;
        hi_phase <= 1'b0;
      end else begin
        hi_phase <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_a <= '0;
      aux_a <= '0;
      pri_b <= '0;
      aux_b <= '0;
    end else if (out_stb) begin
      if (hit_a) begin
        if (aux_a_sel) aux_a <= wdata;
        else           pri_a <= wdata;
      end
      if (hit_b) begin
        if (aux_b_sel) begin
          if (hi_phase) aux_b[BW-1:W] <= wdata;
          else          aux_b[W-1:0]  <= wdata;
        end else begin
          pri_b <= wdata;
        end
      end
    end
  end

  logic [W-1:0] rd;
  always_comb begin
    rd = '0;
    if (in_stb) begin
      if (addr == SW_ADDR)  rd = armed ? target : '0;
      else if (hit_a)       rd = aux_a_sel ? aux_a : pri_a;
      else if (hit_b)       rd = aux_b_sel ? (hi_phase ? aux_b[BW-1:W] : aux_b[W-1:0]) : pri_b;
    end
  end
  assign rdata = rd;
endmodule

// File: rtl/auxsw_nibble_bus_chk.sv
module auxsw_nibble_bus_chk #(
  parameter int W = 4,
  parameter logic [W-1:0] SW_ADDR   = 4'hF,
  parameter logic [W-1:0] NIB_ADDR  = 4'h3,
  parameter logic [W-1:0] BYTE_ADDR = 4'h5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] addr,
  input logic [W-1:0] wdata,
  input logic         out_stb,
  input logic         in_stb,
  input logic [W-1:0] rdata,
  input logic         armed,
  input logic [W-1:0] target,
  input logic [W-1:0] pri_a,
  input logic [W-1:0] pri_b
);
  p_rdata_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_stb |-> rdata == '0);

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stb && addr != SW_ADDR && addr != NIB_ADDR && addr != BYTE_ADDR) |-> rdata == '0);

  p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_stb && addr == SW_ADDR) |=> (armed && target == $past(wdata)));

  p_nib_disarm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && target == NIB_ADDR && addr == NIB_ADDR && (in_stb || out_stb)) |=> !armed);

  p_other_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (in_stb || out_stb) && addr != target && addr != SW_ADDR)
      |=> (armed && $stable(target)));

  p_pri_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_stb |=> ($stable(pri_a) && $stable(pri_b)));
endmodule

bind auxsw_nibble_bus auxsw_nibble_bus_chk #(
  .W(W), .SW_ADDR(SW_ADDR), .NIB_ADDR(NIB_ADDR), .BYTE_ADDR(BYTE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .out_stb(out_stb),
  .in_stb(in_stb), .rdata(rdata), .armed(armed), .target(target),
  .pri_a(pri_a), .pri_b(pri_b)
);

// File: tb/auxsw_nibble_bus_test.sv
module auxsw_nibble_bus_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic       out_stb = 1'b0, in_stb = 1'b0;
  logic [3:0] rdata;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  auxsw_nibble_bus uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
                        .out_stb(out_stb), .in_stb(in_stb), .rdata(rdata));

  // bench model, built from the requirements
  logic       m_arm;
  logic [3:0] m_tgt, m_pa, m_xa, m_pb;
  logic [7:0] m_xb;
  logic       m_hi;

  function automatic logic [3:0] exp_read(input logic [3:0] a);
    if (a == 4'hF) return m_arm ? m_tgt : 4'h0;
    if (a == 4'h3) return (m_arm && m_tgt == 4'h3) ? m_xa : m_pa;
    if (a == 4'h5) return (m_arm && m_tgt == 4'h5) ? (m_hi ? m_xb[7:4] : m_xb[3:0]) : m_pb;
    return 4'h0;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 4'hF) return "R3";
    if (a == 4'h3) return (m_arm && m_tgt == 4'h3) ? "R4" : "R2";
    if (a == 4'h5) return (m_arm && m_tgt == 4'h5) ? "R5" : "R2";
    return "R7";
  endfunction

  task automatic model_update(input logic [3:0] a, input logic [3:0] d, input logic wr);
    if (wr && a == 4'hF) begin
      m_arm = 1'b1; m_tgt = d; m_hi = 1'b0;
    end else if (a == 4'h3) begin
      if (m_arm && m_tgt == 4'h3) begin
        if (wr) m_xa = d;
        m_arm = 1'b0;
      end else if (wr) m_pa = d;
    end else if (a == 4'h5) begin
      if (m_arm && m_tgt == 4'h5) begin
        if (wr) begin
          if (m_hi) m_xb[7:4] = d; else m_xb[3:0] = d;
        end
        if (m_hi) begin m_arm = 1'b0; m_hi = 1'b0; end
        else m_hi = 1'b1;
      end else if (wr) m_pb = d;
    end
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: rdata=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_out(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk);
    addr = a; wdata = d; out_stb = 1'b1;
    #2 check("R8", rdata, 4'h0);
    @(posedge clk);
    model_update(a, d, 1'b1);
    @(negedge clk);
    out_stb = 1'b0;
  endtask

  task automatic do_in(input logic [3:0] a, input string req);
    logic [3:0] e;
    @(negedge clk);
    addr = a; in_stb = 1'b1;
    e = exp_read(a);
    #2 check(req, rdata, e);
    @(posedge clk);
    model_update(a, 4'h0, 1'b0);
    @(negedge clk);
    in_stb = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_arm = 0; m_tgt = 0; m_pa = 0; m_xa = 0; m_pb = 0; m_xb = 0; m_hi = 0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    do_in(4'h3, "R1"); do_in(4'h5, "R1"); do_in(4'hF, "R1");
    // R2 primary
    do_out(4'h3, 4'hA); do_out(4'h5, 4'h6);
    do_in(4'h3, "R2"); do_in(4'h5, "R2");
    // R3 arm and read back target
    do_out(4'hF, 4'h3); do_in(4'hF, "R3");
    // R6 other module unaffected while armed
    do_out(4'h5, 4'h9); do_in(4'h5, "R6"); do_in(4'hF, "R6");
    // R4 nibble aux then back to primary
    do_out(4'h3, 4'hC);
    do_in(4'hF, "R4"); do_in(4'h3, "R4");
    do_out(4'hF, 4'h3); do_in(4'h3, "R4");
    // R5 byte aux low then high
    do_out(4'hF, 4'h5); do_out(4'h5, 4'h1); do_out(4'h5, 4'hE);
    do_in(4'h5, "R5"); do_in(4'hF, "R5");
    do_out(4'hF, 4'h5); do_in(4'h5, "R5"); do_in(4'h5, "R5"); do_in(4'h5, "R5");
    // R5 re-arm mid-byte restarts at low nibble
    do_out(4'hF, 4'h5); do_in(4'h5, "R5"); do_out(4'hF, 4'h5); do_in(4'h5, "R5");
    do_in(4'h5, "R5");
    // R7 unmapped
    do_out(4'h7, 4'hF); do_in(4'h7, "R7"); do_in(4'h0, "R7");
    do_in(4'h3, "R7"); do_in(4'h5, "R7");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [3:0] a, d;
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) a = 4'h3; else if (k < 6) a = 4'h5; else if (k < 8) a = 4'hF;
      else a = 4'($urandom_range(0, 15));
      d = 4'($urandom_range(0, 15));
      if (a == 4'hF && $urandom_range(0, 3) != 0) d = ($urandom_range(0, 1) != 0) ? 4'h3 : 4'h5;
      if ($urandom_range(0, 1) != 0) do_out(a, d);
      else do_in(a, tag_of(a));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule